// File: doc/BRIEF.md
# Constant-Time Modular Inverter

This block computes the multiplicative inverse of an operand `x` modulo an odd modulus `n`, where `x < n` and `gcd(x, n) = 1`. It follows a binary extended-Euclid scheme. Two working values start at `x` and `n`. Two coefficients start at 1 and 0 and track them modulo `n`. The iteration count is fixed by the bit length of the modulus. It never depends on the operand or on how fast the working value collapses.

Every data-dependent choice inside an iteration is a bitwise mask select. The mask is all ones or all zeros, and the select has the form `(m & (p ^ q)) ^ p`. The datapath is limited to add, subtract, negate, compare and a one-bit right shift. One iteration completes per clock. A caller pulses `start` with `x` and `n`, then waits for the `done` pulse and reads `result`. Because the latency is fixed by `n` alone, a secret operand cannot be inferred from timing. Non-invertible operands and even moduli are the caller's concern.

Top module: `modinv_ct`

## Requirements
- R1: After reset `done` is low and `result` is zero.
- R2: For odd `n >= 3` and `1 <= x < n` with `gcd(x, n) = 1`, the `result` present when `done` is high satisfies `(x * result) mod n = 1`.
- R3: Let L be the bit length of `n`, floor(log2 n) + 1. `done` rises exactly 2L+2 falling clock edges after the falling edge on which `start` is presented, which is 2L+1 rising edges after the rising edge that samples `start`. The latency is the same for every `x` and the same `n`.
- R4: `done` is high for exactly one clock cycle per computation.
- R5: A `start` pulse that arrives while a computation is running is ignored. The running computation keeps its latency and returns the inverse of the operand it was started with.
- R6: `result` changes only in the cycle in which `done` rises, and holds its value between computations.
- R7: Corner operands give their known inverses: `x = 1` gives 1, and `x = n-1` gives `n-1`. This holds for the smallest modulus 3 and for the all-ones full-width modulus.
- R8: During a computation the second working value stays odd, and both coefficients stay strictly below `n`. As a result, `result` is always below `n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation with the present `x` and `n`; ignored while busy |
| x | input | W | Operand to invert, below `n` |
| n | input | W | Odd modulus |
| result | output | W | Inverse of the last completed operand |
| done | output | 1 | One-cycle pulse marking a new `result` |

## Verification
The hardest situation to reach from the ports is a second `start` pulse landing mid-computation with a different operand. Such a pulse must leave both the latency and the answer of the running job untouched. The stimulus drives such a pulse a few cycles into selected runs. The behavioural model ignores it, and the per-clock comparison catches any reload. A wide spread of modulus bit lengths, from 2 bits to the full 32-bit width, exercises the length-dependent iteration count at both ends.

// File: rtl/modinv_ct.sv
module modinv_ct #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] x,
  input  logic [W-1:0] n,
  output logic [W-1:0] result,
  output logic         done
);

  localparam int CW = $clog2(2*W+1);

  logic [W-1:0]  a, b, u, v, nr;
  logic [CW-1:0] cnt, len, iters;
  logic          busy;

  function automatic logic [W-1:0] pick(input logic [W-1:0] m,
                                        input logic [W-1:0] p0,
                                        input logic [W-1:0] p1);
    return (m & (p0 ^ p1)) ^ p0;
  endfunction

  always_comb begin
    len = '0;
    for (int i = 0; i < W; i++)
      if (n[i]) len = CW'(i + 1);
  end
  assign iters = len << 1;

  logic         odd, lt;
  logic [W:0]   dab, duv, uh;
  logic [W-1:0] mo, ms, mneg, dneg, a1, b1, u1, v1, u2, u3;

  assign odd  = a[0];
  assign dab  = {1'b0, a} - {1'b0, b};
  assign lt   = dab[W];
  assign mo   = {W{odd}};
  assign ms   = {W{odd & lt}};
  assign dneg = {W{1'b0}} - dab[W-1:0];

  assign a1 = pick(mo, a, pick(ms, dab[W-1:0], dneg));
  assign b1 = pick(ms, b, a);
  assign u1 = pick(ms, u, v);
  assign v1 = pick(ms, v, u);

  assign duv  = {1'b0, u1} - {1'b0, v1};
  assign mneg = {W{duv[W]}};
  assign u2   = pick(mo, u1, pick(mneg, duv[W-1:0], duv[W-1:0] + nr));
  assign uh   = {1'b0, u2} + ({(W+1){u2[0]}} & {1'b0, nr});
  assign u3   = W'(uh >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      a      <= '0;
      b      <= '0;
      u      <= '0;
      v      <= '0;
      nr     <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt != '0) begin
          a   <= a1 >> 1;
          b   <= b1;
          u   <= u3;
          v   <= v1;
          cnt <= cnt - CW'(1);
        end else begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= v;
        end
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= iters;
        a    <= x;
        b    <= n;
        u    <= W'(1);
        v    <= '0;
        nr   <= n;
      end
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy) && $past(cnt) == '0);

  a_r5_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |=> busy && cnt == $past(cnt) - CW'(1));

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  a_r8_b_odd: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> b[0]);

  a_r8_coeff_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> u < nr && v < nr);

endmodule

// File: tb/sim_modinv_ct.sv
`timescale 1ns/1ps
module sim_modinv_ct;
  localparam int W = 32;

  logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] x = '0, n = '0;
  logic [W-1:0] result;
  logic         done;

  modinv_ct #(.W(W)) u0 (.clk(clk), .rst_n(rst_n), .start(start), .x(x), .n(n),
                         .result(result), .done(done));

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit armed = 0, m_busy = 0, m_done = 0;
  int m_cd = 0;
  logic [W-1:0] m_pend = '0, m_res = '0;

  function automatic int bitlen(input logic [W-1:0] v);
    int l = 0;
    for (int i = 0; i < W; i++) if (v[i]) l = i + 1;
    return l;
  endfunction

  function automatic longint gcd(input longint p, input longint q);
    longint t;
    while (q != 0) begin t = p % q; p = q; q = t; end
    return p;
  endfunction

  function automatic logic [W-1:0] ref_inv(input logic [W-1:0] xv, input logic [W-1:0] nv);
    longint r0, r1, t0, t1, q, tmp;
    r0 = longint'(nv); r1 = longint'(xv); t0 = 0; t1 = 1;
    while (r1 != 0) begin
      q = r0 / r1;
      tmp = r0 - q * r1; r0 = r1; r1 = tmp;
      tmp = t0 - q * t1; t0 = t1; t1 = tmp;
    end
    if (t0 < 0) t0 = t0 + longint'(nv);
    return W'(t0);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
    if (!rst_n) begin
      armed = 1; m_busy = 0; m_done = 0; m_cd = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cd == 0) begin m_busy = 0; m_done = 1; m_res = m_pend; end
        else m_cd--;
      end else if (start) begin
        m_busy = 1; m_cd = 2 * bitlen(n); m_pend = ref_inv(x, n);
      end
    end
  end

  always @(negedge clk) if (armed) begin
    chk(done === m_done, "R3 R4 done timing", 64'(done), 64'(m_done));
    chk(result === m_res, "R2 R6 result", 64'(result), 64'(m_res));
  end

  task automatic run(input logic [W-1:0] xi, input logic [W-1:0] ni, input bit poke);
    int waited = 0;
    logic [63:0] prod;
    logic [W-1:0] held;
    @(negedge clk); x = xi; n = ni; start = 1'b1;
    @(negedge clk); start = 1'b0; waited = 1;
    if (poke) begin
      repeat (2) begin @(negedge clk); waited++; end
      x = xi ^ W'(2); start = 1'b1;
      @(negedge clk); waited++; start = 1'b0;
    end
    while (!done && waited < 1000) begin @(negedge clk); waited++; end
    chk(waited == 2*bitlen(ni) + 2, "R3 R5 latency", 64'(waited), 64'(2*bitlen(ni)+2));
    prod = {32'b0, xi} * {32'b0, result};
    chk(prod % {32'b0, ni} == 64'd1, "R2 R5 inverse", prod % {32'b0, ni}, 64'd1);
    chk(result < ni, "R8 result range", 64'(result), 64'(ni));
    held = result;
    @(negedge clk);
    chk(!done, "R4 pulse width", 64'(done), 64'd0);
    chk(result == held, "R6 hold", 64'(result), 64'(held));
  endtask

  initial begin
    logic [W-1:0] nn, xx;
    repeat (4) @(negedge clk);
    chk(done === 1'b0, "R1 reset done", 64'(done), 64'd0);
    chk(result === '0, "R1 reset result", 64'(result), 64'd0);
    rst_n = 1'b1;
    run(32'd1, 32'd3, 0); chk(result == 32'd1, "R7 x=1 n=3", 64'(result), 64'd1);
    run(32'd2, 32'd3, 0); chk(result == 32'd2, "R7 x=n-1 n=3", 64'(result), 64'd2);
    run(32'd1, 32'hFFFFFFFF, 0); chk(result == 32'd1, "R7 x=1 full", 64'(result), 64'd1);
    run(32'hFFFFFFFE, 32'hFFFFFFFF, 0);
    chk(result == 32'hFFFFFFFE, "R7 x=n-1 full", 64'(result), 64'hFFFFFFFE);
    run(32'd7, 32'hFFFFFFFF, 0);
    run(32'd1, 32'd1000003, 1);
    run(32'd1000002, 32'd1000003, 0);
    chk(result == 32'd1000002, "R7 x=n-1 mid", 64'(result), 64'd1000002);
    for (int k = 0; k < 250; k++) begin
      nn = ($urandom >> ($urandom % 31)) | 32'd1;
      if (nn < 32'd3) nn = 32'd3;
      xx = ($urandom % nn);
      while (xx == '0 || gcd(longint'(xx), longint'(nn)) != 1) xx = ($urandom % nn);
      run(xx, nn, (k % 7) == 3 && nn > 32'd4);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule